// File: doc/BRIEF.md
# Smart Card Fault Interrupt Supervisor

This block supervises the electrical state around a smart card slot. It filters a mechanical card-presence switch, watches a card-supply overload flag, a card-supply low-voltage flag and a battery undervoltage comparator, and combines their events into one active-low interrupt line that a host can wire-AND with other supervisors. A small status vector reports card presence, supply low-voltage and a latched overload fault, so that a shared interrupt can be traced back to its cause.

The presence switch is normally open after reset, so a card arriving pulls the detect line from high to low. A one-bit configuration write selects a normally-closed switch instead, where a card arriving drives the line from low to high. Only filtered transitions count as insertions, so a card already seated when the polarity is changed is not announced. An overload that persists for a parameterized number of clock cycles turns the converter enable off. The enable stays off until the power request is dropped and raised again. The host clears the interrupt with a rising edge on either the chip-select or the power request input.

Top module: `cardsup_top`

## Requirements
- R1: After reset irq_n_o is 1, status_o is 0, stat_ok_o is 1 and conv_en_o follows pwr_on_i.
- R2: With the default normally-open polarity (cfg_nc_i written 0), a high-to-low change on det_i that is held through synchronization and debounce drives irq_n_o low and sets status_o[0] (card present). The opposite change clears status_o[0] and raises no interrupt.
- R3: Writing cfg_nc_i=1 with cfg_we_i selects a normally-closed switch: a filtered low-to-high change on det_i becomes the insertion event, and status_o[0] is 1 while det_i is high.
- R4: A polarity write while det_i is steady raises no interrupt. status_o[0] is updated to the new interpretation of the steady level.
- R5: A level on det_i that lasts fewer than DEB_CYC cycles after the two-flop synchronizer changes neither status_o[0] nor irq_n_o.
- R6: A rising edge on sel_i or on pwr_on_i returns irq_n_o to 1 on the next clock edge, unless a new event is raised in that same cycle.
- R7: A rising edge on vlow_i drives irq_n_o low and status_o[1] mirrors vlow_i one cycle later. conv_en_o is not affected.
- R8: ovl_i held high for OVL_CYC consecutive cycles while the supply is enabled forces conv_en_o low, drives irq_n_o low and sets status_o[2]. A shorter overload restarts the count and has no effect.
- R9: After an overload shutdown, conv_en_o stays low until pwr_on_i has been low for at least one cycle and is then raised again. An interrupt clear alone does not restore it.
- R10: While bat_uv_i is high, conv_en_o is 0, stat_ok_o goes low on the next cycle, and card insertions raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| det_i | input | 1 | Raw card-presence switch level, pulled high when open |
| ovl_i | input | 1 | Card-supply overload flag |
| vlow_i | input | 1 | Card-supply low-voltage flag |
| bat_uv_i | input | 1 | Battery undervoltage comparator output |
| sel_i | input | 1 | Chip-select; a rising edge clears the interrupt |
| pwr_on_i | input | 1 | Card power request; a rising edge clears the interrupt |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_nc_i | input | 1 | Polarity bit written on cfg_we_i: 1 selects a normally-closed switch |
| irq_n_o | output | 1 | Active-low interrupt |
| conv_en_o | output | 1 | Card-supply converter enable |
| status_o | output | 3 | [0] card present, [1] supply low, [2] overload fault |
| stat_ok_o | output | 1 | Low while the battery is undervoltage |

## Verification
Detection is driven through a vector sequence that alternates switch levels under both polarities. This tells an insertion apart from a removal, and it separates a real transition from a polarity rewrite over a steady level. A short detect glitch checks that the debounce rejects pulses. Overload bursts just below and well beyond the timeout check that the timer restarts and that the shutdown latches. The shutdown is then released by an interrupt clear and by a power-request cycle, and the two outcomes are compared. Low-voltage and battery-undervoltage stimuli check that one only reports and the other inhibits.

// File: rtl/cardsup_pkg.sv
package cardsup_pkg;

    typedef struct packed {
        logic ovl_fault;
        logic vlow;
        logic present;
    } cardsup_stat_t;

    localparam int STAT_W = $bits(cardsup_stat_t);

    // Level the filtered switch settles at when a card is inserted.
    function automatic logic ins_level(input logic nc_sel);
        return nc_sel;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/cardsup_detect.sv
module cardsup_detect
    import cardsup_pkg::*;
#(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic det_raw,
    input  logic nc_sel,
    output logic stable_o,
    output logic ins_o
);
    localparam int CW = cnt_width(DEB_CYC);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic          s1_q, s2_q, stable_q, ins_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= 1'b1;
            s2_q     <= 1'b1;
            stable_q <= 1'b1;
            cnt_q    <= '0;
            ins_q    <= 1'b0;
        end else begin
            s1_q  <= det_raw;
            s2_q  <= s1_q;
            ins_q <= 1'b0;
            if (s2_q != stable_q) begin
                if (cnt_q == LAST) begin
                    stable_q <= s2_q;
                    cnt_q    <= '0;
                    ins_q    <= (s2_q == ins_level(nc_sel));
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign stable_o = stable_q;
    assign ins_o    = ins_q;

    // R5: the filtered level only moves after a full debounce window
    assert_debounce_window_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(stable_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/cardsup_ovl_timer.sv
module cardsup_ovl_timer
    import cardsup_pkg::*;
#(
    parameter int OVL_CYC = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ovl,
    output logic trip_o
);
    localparam int CW = cnt_width(OVL_CYC);
    localparam logic [CW-1:0] LAST = CW'(OVL_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign trip_o = en && ovl && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || !ovl || trip_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the count never runs past the timeout
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R8: a dropped overload restarts the window
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        !ovl |=> (cnt_q == '0));

endmodule

// File: rtl/cardsup_top.sv
module cardsup_top
    import cardsup_pkg::*;
#(
    parameter int DEB_CYC = 16,
    parameter int OVL_CYC = 200000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             det_i,
    input  logic             ovl_i,
    input  logic             vlow_i,
    input  logic             bat_uv_i,
    input  logic             sel_i,
    input  logic             pwr_on_i,
    input  logic             cfg_we_i,
    input  logic             cfg_nc_i,
    output logic             irq_n_o,
    output logic             conv_en_o,
    output logic [STAT_W-1:0] status_o,
    output logic             stat_ok_o
);
    logic nc_q, sel_q, pwr_q, vlow_q, pend_q, tripped_q, ok_q;
    logic stable, ins_evt, trip, active, clr_evt, set_evt;
    cardsup_stat_t stat;

    assign active = !bat_uv_i;

    cardsup_detect #(.DEB_CYC(DEB_CYC)) u_det (
        .clk     (clk),
        .rst     (rst),
        .det_raw (det_i),
        .nc_sel  (nc_q),
        .stable_o(stable),
        .ins_o   (ins_evt)
    );

    cardsup_ovl_timer #(.OVL_CYC(OVL_CYC)) u_ovl (
        .clk   (clk),
        .rst   (rst),
        .en    (conv_en_o),
        .ovl   (ovl_i),
        .trip_o(trip)
    );

    assign clr_evt = (sel_i && !sel_q) || (pwr_on_i && !pwr_q);
    assign set_evt = (ins_evt && active) || trip || (vlow_i && !vlow_q && active);

    always_ff @(posedge clk) begin
        if (rst) begin
            nc_q      <= 1'b0;
            sel_q     <= 1'b0;
            pwr_q     <= 1'b0;
            vlow_q    <= 1'b0;
            pend_q    <= 1'b0;
            tripped_q <= 1'b0;
            ok_q      <= 1'b1;
        end else begin
            if (cfg_we_i) nc_q <= cfg_nc_i;
            sel_q  <= sel_i;
            pwr_q  <= pwr_on_i;
            vlow_q <= vlow_i;
            ok_q   <= active;
            if (set_evt)      pend_q <= 1'b1;
            else if (clr_evt) pend_q <= 1'b0;
            if (!pwr_on_i)    tripped_q <= 1'b0;
            else if (trip)    tripped_q <= 1'b1;
        end
    end

    always_comb begin
        stat.present   = (stable == ins_level(nc_q));
        stat.vlow      = vlow_q;
        stat.ovl_fault = tripped_q;
    end

    assign status_o  = stat;
    assign irq_n_o   = !pend_q;
    assign conv_en_o = pwr_on_i && !tripped_q && active;
    assign stat_ok_o = ok_q;

    // R6: a clear edge with no competing event releases the line
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && !set_evt) |=> irq_n_o);

    // R8: an expired overload window removes the supply
    assert_trip_off_R8: assert property (@(posedge clk) disable iff (rst)
        trip |=> (!conv_en_o && !irq_n_o));

    // R9: a held power request cannot re-enable a supply that is off
    assert_relatch_R9: assert property (@(posedge clk) disable iff (rst)
        (!conv_en_o && pwr_on_i && !bat_uv_i) |=> !conv_en_o);

    // R10: battery undervoltage pulls the status pin low
    assert_uv_status_R10: assert property (@(posedge clk) disable iff (rst)
        bat_uv_i |=> !stat_ok_o);

    // R7: the low-voltage flag reaches status without touching the enable
    assert_vlow_status_R7: assert property (@(posedge clk) disable iff (rst)
        vlow_i |=> status_o[1]);

endmodule

// File: tb/cardsup_top_test.sv
module cardsup_top_test;
    localparam int DEB = 4;
    localparam int OVL = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic det_i = 1'b1, ovl_i = 1'b0, vlow_i = 1'b0, bat_uv_i = 1'b0;
    logic sel_i = 1'b0, pwr_on_i = 1'b0, cfg_we_i = 1'b0, cfg_nc_i = 1'b0;
    logic irq_n_o, conv_en_o, stat_ok_o;
    logic [2:0] status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cardsup_top #(.DEB_CYC(DEB), .OVL_CYC(OVL)) uut (
        .clk(clk), .rst(rst), .det_i(det_i), .ovl_i(ovl_i), .vlow_i(vlow_i),
        .bat_uv_i(bat_uv_i), .sel_i(sel_i), .pwr_on_i(pwr_on_i),
        .cfg_we_i(cfg_we_i), .cfg_nc_i(cfg_nc_i), .irq_n_o(irq_n_o),
        .conv_en_o(conv_en_o), .status_o(status_o), .stat_ok_o(stat_ok_o)
    );

    // {polarity, det level, expected irq_n, expected present}
    localparam int NV = 7;
    localparam logic [3:0] VEC [NV] = '{
        4'b0_1_1_0,  // R2 idle, no card
        4'b0_0_0_1,  // R2 insertion, open switch
        4'b0_1_1_0,  // R2 removal, no interrupt
        4'b1_1_1_1,  // R4 polarity flip over a steady level
        4'b1_0_1_0,  // R3 removal, closed switch
        4'b1_1_0_1,  // R3 insertion, closed switch
        4'b0_1_1_0   // R4 flip back, no interrupt
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sel();
        sel_i = 1'b1; tick(1); sel_i = 1'b0; tick(2);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 irq_n", 8'(irq_n_o), 8'd1);
        chk("R1 status", 8'(status_o), 8'd0);
        chk("R1 stat_ok", 8'(stat_ok_o), 8'd1);
        chk("R1 conv_en", 8'(conv_en_o), 8'd0);
        pwr_on_i = 1'b1;
        tick(2);
        chk("R1 conv_en follows", 8'(conv_en_o), 8'd1);

        for (int i = 0; i < NV; i++) begin
            cfg_nc_i = VEC[i][3]; cfg_we_i = 1'b1; tick(1); cfg_we_i = 1'b0;
            det_i = VEC[i][2];
            tick(12);
            chk($sformatf("R2/R3/R4 step %0d irq_n", i), 8'(irq_n_o), 8'(VEC[i][1]));
            chk($sformatf("R2/R3/R4 step %0d present", i), 8'(status_o[0]), 8'(VEC[i][0]));
            pulse_sel();
            chk($sformatf("R6 sel clear step %0d", i), 8'(irq_n_o), 8'd1);
        end

        // R5: short glitch toward insertion level
        det_i = 1'b0; tick(2); det_i = 1'b1; tick(12);
        chk("R5 glitch irq_n", 8'(irq_n_o), 8'd1);
        chk("R5 glitch present", 8'(status_o[0]), 8'd0);

        // R7: supply low-voltage reports only
        vlow_i = 1'b1; tick(3);
        chk("R7 irq_n", 8'(irq_n_o), 8'd0);
        chk("R7 status vlow", 8'(status_o[1]), 8'd1);
        chk("R7 conv_en kept", 8'(conv_en_o), 8'd1);
        // R6: clear through power-on rising edge
        pwr_on_i = 1'b0; tick(2); pwr_on_i = 1'b1; tick(2);
        chk("R6 pwr_on clear", 8'(irq_n_o), 8'd1);
        vlow_i = 1'b0; tick(2);
        chk("R7 status vlow off", 8'(status_o[1]), 8'd0);

        // R8: short overload restarts
        ovl_i = 1'b1; tick(OVL - 5); ovl_i = 1'b0; tick(2);
        ovl_i = 1'b1; tick(OVL - 5); ovl_i = 1'b0; tick(3);
        chk("R8 short conv_en", 8'(conv_en_o), 8'd1);
        chk("R8 short irq_n", 8'(irq_n_o), 8'd1);
        chk("R8 short status", 8'(status_o[2]), 8'd0);
        // R8: sustained overload trips
        ovl_i = 1'b1; tick(OVL + 5); ovl_i = 1'b0; tick(2);
        chk("R8 trip conv_en", 8'(conv_en_o), 8'd0);
        chk("R8 trip irq_n", 8'(irq_n_o), 8'd0);
        chk("R8 trip status", 8'(status_o[2]), 8'd1);
        // R9: clearing the interrupt does not restore supply
        pulse_sel();
        chk("R9 irq cleared", 8'(irq_n_o), 8'd1);
        chk("R9 still off", 8'(conv_en_o), 8'd0);
        pwr_on_i = 1'b0; tick(2); pwr_on_i = 1'b1; tick(2);
        chk("R9 restored", 8'(conv_en_o), 8'd1);
        chk("R9 fault cleared", 8'(status_o[2]), 8'd0);

        // R10: battery undervoltage inhibits
        bat_uv_i = 1'b1; tick(2);
        chk("R10 conv_en", 8'(conv_en_o), 8'd0);
        chk("R10 stat_ok", 8'(stat_ok_o), 8'd0);
        det_i = 1'b0; tick(12);
        chk("R10 no insertion irq", 8'(irq_n_o), 8'd1);
        bat_uv_i = 1'b0; tick(2);
        chk("R10 stat_ok back", 8'(stat_ok_o), 8'd1);
        chk("R10 conv_en back", 8'(conv_en_o), 8'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule